// File: doc/BRIEF.md
# Block Lock State Manager

This block holds the write-protection state of every erase block in a flash array. The command front end hands it decoded bus write cycles: a command byte, a block number and a one-cycle write strobe. A protection change always takes two writes. The first write is a setup code. The second write names the action, and its block number selects the target. The block drives a protection vector with one bit per erase block, which the program and erase engines read. It also raises a pulse when the action write after a setup is not one of the known codes.

Each block is in one of three states: open, locked or locked-down. Software can move a block between open and locked as often as it likes. Once a block is locked-down, software unlock requests are ignored without any error, and only a reset releases the block. Reset returns every block to locked. Writes that carry a code other than the setup code are left to other command handlers unless a setup write came before them.

Top module: `blk_prot_mgr`

## Requirements
- R1: After reset every block is locked: each bit of `prot_vec` is 1 and `seq_err` is 0.
- R2: A write of 0x60 followed by a write of 0x01 sets the block named in the second write to locked (`prot_vec` bit 1), unless that block is locked-down. The change is visible the cycle after the second write.
- R3: A write of 0x60 followed by a write of 0xD0 sets the named block to open (`prot_vec` bit 0) when it is not locked-down.
- R4: 0x60 then 0xD0 aimed at a locked-down block changes nothing and raises no error. That block's bit stays 1.
- R5: 0x60 then 0x2F sets the named block to locked-down (`prot_vec` bit 1).
- R6: 0x60 then 0x01 aimed at a locked-down block leaves it locked-down, so a later unlock attempt on it still has no effect.
- R7: Any code other than 0x01, 0xD0 or 0x2F written right after 0x60 leaves every block unchanged and pulses `seq_err` high for exactly one cycle, the cycle after that write. The next write is then treated as a new first write.
- R8: 0x01, 0xD0 or 0x2F written without a preceding 0x60 changes no block and raises no error.
- R9: An action changes only the addressed block. All other bits of `prot_vec` keep their values.
- R10: Reset releases lock-down. After a reset, a block that was locked-down can be unlocked by 0x60 then 0xD0.
- R11: Cycles with `cmd_we` low are ignored. A pending setup survives idle cycles and is completed by the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Write strobe; one command cycle per high clock |
| cmd_data | input | 8 | Command code of the cycle |
| cmd_blk | input | BLK_W | Block number of the cycle |
| prot_vec | output | NUM_BLK | Per-block protection, 1 = locked or locked-down |
| seq_err | output | 1 | One-cycle pulse on a bad action code after setup |

## Verification
The bench targets the lock-down trap from every side. An unlock, and then a lock followed by an unlock, are sent to a locked-down block. A design that let either request through would clear that block's bit. A reset must then release the block; a design that kept lock-down across reset would refuse the unlock. Bare action codes with no setup, and a setup separated from its action by idle cycles, expose a sequencer that arms on the wrong cycle or forgets its setup. The bench also sends a bad code after setup and then a bare unlock. A design that stayed armed after the error would unlock the block, and one that held the error flag would show a pulse longer than one cycle. The lowest and highest block numbers are exercised to catch decode slips at the ends of the range.

// File: rtl/blk_prot_pkg.sv
package blk_prot_pkg;

   localparam logic [7:0] CODE_SETUP  = 8'h60;
   localparam logic [7:0] CODE_LOCK   = 8'h01;
   localparam logic [7:0] CODE_UNLOCK = 8'hD0;
   localparam logic [7:0] CODE_LDOWN  = 8'h2F;

   // two-bit stored state; bit 0 doubles as the protection flag
   typedef enum logic [1:0] {
      ST_OPEN  = 2'b00,
      ST_LOCK  = 2'b01,
      ST_LDOWN = 2'b11
   } prot_st_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'd0,
      ACT_LOCK   = 2'd1,
      ACT_UNLOCK = 2'd2,
      ACT_LDOWN  = 2'd3
   } prot_act_e;

endpackage

// File: rtl/blk_prot_seq.sv
module blk_prot_seq
   import blk_prot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_we,
   input  logic [7:0] cmd_data,
   output prot_act_e  act,
   output logic       seq_err
);

   logic      armed_q;
   logic      err_q;
   prot_act_e code_act;

   always_comb begin
      unique case (cmd_data)
         CODE_LOCK:   code_act = ACT_LOCK;
         CODE_UNLOCK: code_act = ACT_UNLOCK;
         CODE_LDOWN:  code_act = ACT_LDOWN;
         default:     code_act = ACT_NONE;
      endcase
   end

   // an action reaches the cells only as the second write of a pair
   assign act = (cmd_we && armed_q) ? code_act : ACT_NONE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         err_q <= cmd_we && armed_q && (code_act == ACT_NONE);
         if (cmd_we)
            armed_q <= !armed_q && (cmd_data == CODE_SETUP);
      end
   end

   assign seq_err = err_q;

   // R8: a write while idle never yields an error
   a_r8_idle_no_err : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !armed_q) |=> !seq_err);

   // R11: idle cycles keep a pending setup
   a_r11_hold_armed : assert property (@(posedge clk) disable iff (!rst_n)
      (!cmd_we && armed_q) |=> armed_q);

endmodule

// File: rtl/blk_prot_dec.sv
module blk_prot_dec #(
   parameter int NUM_BLK = 64,
   parameter int BLK_W   = 6
) (
   input  logic [BLK_W-1:0]   blk,
   output logic [NUM_BLK-1:0] hit
);

   generate
      if ((1 << BLK_W) < NUM_BLK) begin : g_bad_w
         $error("blk_prot_dec: BLK_W too narrow for NUM_BLK");
      end
      for (genvar i = 0; i < NUM_BLK; i++) begin : g_hit
         assign hit[i] = (blk == BLK_W'(i));
      end
   endgenerate

   // R9: at most one block is addressed
   always_comb begin
      a_r9_one_hit : assert ($onehot0(hit));
   end

endmodule

// File: rtl/blk_prot_cell.sv
module blk_prot_cell
   import blk_prot_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hit,
   input  prot_act_e act,
   output logic      prot
);

   prot_st_e st_q;
   prot_st_e st_d;

   always_comb begin
      st_d = st_q;
      if (hit && st_q != ST_LDOWN) begin
         unique case (act)
            ACT_LOCK:   st_d = ST_LOCK;
            ACT_UNLOCK: st_d = ST_OPEN;
            ACT_LDOWN:  st_d = ST_LDOWN;
            default:    st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_LOCK;
      else        st_q <= st_d;
   end

   assign prot = st_q[0];

   a_r2_lock : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && act == ACT_LOCK && st_q != ST_LDOWN) |=> st_q == ST_LOCK);

   a_r3_unlock : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && act == ACT_UNLOCK && st_q != ST_LDOWN) |=> !prot);

   a_r5_ldown : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && act == ACT_LDOWN) |=> st_q == ST_LDOWN);

   // R4 / R6: lock-down only leaves through reset
   a_r4_ldown_sticky : assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LDOWN) |=> (st_q == ST_LDOWN && prot));

   a_r9_untouched : assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> $stable(st_q));

endmodule

// File: rtl/blk_prot_mgr.sv
module blk_prot_mgr
   import blk_prot_pkg::*;
#(
   parameter  int NUM_BLK = 64,
   localparam int BLK_W   = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_we,
   input  logic [7:0]         cmd_data,
   input  logic [BLK_W-1:0]   cmd_blk,
   output logic [NUM_BLK-1:0] prot_vec,
   output logic               seq_err
);

   generate
      if (NUM_BLK < 2) begin : g_bad_n
         $error("blk_prot_mgr: NUM_BLK must be at least 2");
      end
   endgenerate

   prot_act_e          act;
   logic [NUM_BLK-1:0] hit;

   blk_prot_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (cmd_we),
      .cmd_data (cmd_data),
      .act      (act),
      .seq_err  (seq_err)
   );

   blk_prot_dec #(.NUM_BLK(NUM_BLK), .BLK_W(BLK_W)) u_dec (
      .blk (cmd_blk),
      .hit (hit)
   );

   generate
      for (genvar i = 0; i < NUM_BLK; i++) begin : g_cell
         blk_prot_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .hit   (hit[i]),
            .act   (act),
            .prot  (prot_vec[i])
         );
      end
   endgenerate

   // R7: error is a single-cycle pulse and comes with no state change
   a_r7_err_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> !seq_err);

   a_r7_err_no_change : assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> $stable(prot_vec));

   // R8 / R9: without an action, protection holds
   a_r9_quiet_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_NONE) |=> $stable(prot_vec));

endmodule

// File: tb/blk_prot_mgr_test.sv
module blk_prot_mgr_test;

   localparam int N  = 64;
   localparam int BW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_we = 1'b0;
   logic [7:0]    cmd_data = 8'h00;
   logic [BW-1:0] cmd_blk = '0;
   logic [N-1:0]  prot_vec;
   logic          seq_err;

   always #10 clk = ~clk;

   blk_prot_mgr #(.NUM_BLK(N)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
      .cmd_blk(cmd_blk), .prot_vec(prot_vec), .seq_err(seq_err)
   );

   typedef struct {
      string        tag;
      logic         err;
      logic [N-1:0] prot;
   } exp_t;

   exp_t q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 0;

   // reference model: 0 open, 1 locked, 3 locked-down
   int   mst[N];
   bit   m_armed;

   function automatic logic [N-1:0] m_prot();
      logic [N-1:0] v;
      for (int i = 0; i < N; i++) v[i] = (mst[i] != 0);
      return v;
   endfunction

   task automatic push(input string tag, input logic err);
      exp_t e;
      e.tag = tag; e.err = err; e.prot = m_prot();
      q.push_back(e);
   endtask

   task automatic wr(input logic [7:0] d, input int b, input string tag);
      logic err;
      @(negedge clk);
      cmd_data = d; cmd_blk = BW'(b); cmd_we = 1'b1;
      @(posedge clk);
      #1 cmd_we = 1'b0;
      err = 1'b0;
      if (m_armed) begin
         m_armed = 0;
         case (d)
            8'h01: if (mst[b] != 3) mst[b] = 1;
            8'hD0: if (mst[b] != 3) mst[b] = 0;
            8'h2F: mst[b] = 3;
            default: err = 1'b1;
         endcase
      end else if (d == 8'h60) begin
         m_armed = 1;
      end
      push(tag, err);
   endtask

   task automatic idle(input string tag);
      @(negedge clk);
      @(posedge clk);
      #1 push(tag, 1'b0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) mst[i] = 1;
      m_armed = 0;
      @(negedge clk);
      @(negedge clk);
      n_cmp++;
      if (prot_vec !== {N{1'b1}} || seq_err !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset state: prot=%h err=%b expected prot=%h err=0",
                  prot_vec, seq_err, {N{1'b1}});
      end
      rst_n = 1'b1;
   endtask

   // monitor: compare one expected item per cycle
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (prot_vec !== e.prot || seq_err !== e.err) begin
               n_bad++;
               $display("FAIL %s: prot=%h err=%b expected prot=%h err=%b",
                        e.tag, prot_vec, seq_err, e.prot, e.err);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      idle("R1 idle after reset");
      // R3 unlock and R9 neighbours untouched
      wr(8'h60, 3, "R3 setup");
      wr(8'hD0, 3, "R3 unlock blk3");
      // R8 bare codes ignored
      wr(8'hD0, 5, "R8 bare unlock");
      wr(8'h01, 3, "R8 bare lock");
      wr(8'h2F, 6, "R8 bare lockdown");
      // R5 lock-down, R4 unlock ignored
      wr(8'h60, 7, "R5 setup");
      wr(8'h2F, 7, "R5 lockdown blk7");
      wr(8'h60, 7, "R4 setup");
      wr(8'hD0, 7, "R4 unlock on lockdown");
      // R6 lock on lock-down stays lock-down
      wr(8'h60, 7, "R6 setup");
      wr(8'h01, 7, "R6 lock on lockdown");
      wr(8'h60, 7, "R6 setup2");
      wr(8'hD0, 7, "R6 unlock probe");
      // R7 bad code after setup
      wr(8'h60, 3, "R7 setup");
      wr(8'h55, 3, "R7 bad code");
      wr(8'hD0, 9, "R7 disarmed after error");
      wr(8'h60, 3, "R7 setup setup");
      wr(8'h60, 3, "R7 repeated setup is error");
      idle("R7 pulse ended");
      // R11 setup survives idle cycles
      wr(8'h60, 9, "R11 setup");
      idle("R11 idle1");
      idle("R11 idle2");
      wr(8'hD0, 9, "R11 unlock blk9");
      // R2 relock, R9 range ends
      wr(8'h60, 3, "R2 setup");
      wr(8'h01, 3, "R2 lock blk3");
      wr(8'h60, 0, "R9 setup lo");
      wr(8'hD0, 0, "R9 unlock blk0");
      wr(8'h60, N - 1, "R9 setup hi");
      wr(8'hD0, N - 1, "R9 unlock top");
      wr(8'h60, N - 1, "R5 setup top");
      wr(8'h2F, N - 1, "R5 lockdown top");
      wr(8'h60, N - 1, "R4 setup top");
      wr(8'hD0, N - 1, "R4 unlock top ignored");
      idle("drain");
      @(negedge clk);
      // R10 reset releases lock-down
      do_reset();
      wr(8'h60, 7, "R10 setup");
      wr(8'hD0, 7, "R10 unlock after reset");
      wr(8'h60, N - 1, "R10 setup top");
      wr(8'hD0, N - 1, "R10 unlock top after reset");
      idle("final");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule